// File: doc/BRIEF.md
# Video Timing Generator with Early Fetch

This block is the raster timing engine of a display output path. From a set of per-axis timing fields it sweeps a frame one pixel clock at a time, driving horizontal and vertical sync, a data-enable window, a 1-based line number and a frame number. Each axis is laid out as sync pulse, back porch, active region and then front porch. The interface type changes the timing. A command-mode serial panel forces both syncs active-high. A packet-based display link moves the front porch into the back porch, and with a doubled bus width it also halves the horizontal fields.

The upstream pixel pipeline needs time to start the next frame. When the start-of-frame lines (vertical back porch plus vsync width) are fewer than a worst-case line budget, the block computes how many lines of the vertical front porch to borrow. It then emits a one-cycle fetch-start pulse on the matching 1-based pixel count of the frame. Inside the front porch the reported frame number already points at the frame being fetched. When upstream data is missing in the active window, the block outputs a fixed fill colour and flags an underrun.

The run control is a three-state machine. The states are `ST_IDLE` (no sweep), `ST_RUN` (sweeping with enable high) and `ST_STOP` (enable cleared, current frame finishing). The transitions are as follows. IDLE→RUN happens when enable is high, and loads the timing. RUN→STOP happens when enable is low before the last pixel. RUN→RUN happens on the last pixel with enable high, and reloads the timing. RUN→IDLE happens on the last pixel with enable low. STOP→RUN happens on the last pixel with enable high, and reloads the timing. STOP→IDLE happens on the last pixel with enable low. The timing inputs form a shadow set and are copied into the active set only on those loads.

Top module: `frame_timing_gen`

## Requirements
- R1: One frame lasts htot×vtot clocks, where htot = active + front + sync + back for the horizontal axis and vtot is formed the same way for the vertical axis. The logical hsync is asserted for the first sync-width clocks of each line. The logical vsync is asserted for the first sync-width lines of each frame.
- R2: Setting hsync_low or vsync_low inverts that sync output. When link_kind is 1 (serial panel), both syncs stay active-high whatever those bits say.
- R3: When link_kind is 2 (packet link), each axis uses back porch plus front porch as its back porch and zero as its front porch.
- R4: When link_kind is 2 and wide_bus is 1, the horizontal active width, the folded back porch and the hsync width are each shifted right by one bit.
- R5: de is high exactly when the column lies in [sync+back, sync+back+active) and the line lies in the same window of the vertical fields.
- R6: Fetch lines are 0 if vertical back porch + vsync width ≥ fetch_budget; otherwise they are min(front porch, fetch_budget − (back porch + vsync width)). With fetch lines nonzero, fetch_start pulses for one clock when the 1-based pixel count of the frame equals (vtot − fetch lines)×htot + 1. With fetch lines zero it never pulses.
- R7: line_cnt is the 1-based line of the current pixel (0 when idle). frame_cnt is the number of completed frames since reset, plus one while fetch lines are nonzero and line_cnt lies in (vtot − front porch, vtot].
- R8: When de is high and up_valid is low, underrun is high and pix_out is 0xFF. When de is high and up_valid is high, pix_out follows up_pixel. When de is low, pix_out is 0.
- R9: vsync_irq is high for exactly the first pixel of each frame.
- R10: Clearing enable takes effect only after the last pixel of the current frame. timing_active stays 1 until then and drops to 0 in the cycle after the last pixel.
- R11: Changes to the timing inputs during a frame do not affect that frame. They apply from the next frame start.
- R12: After reset the block is idle: timing_active, de, fetch_start, vsync_irq and frame_cnt are 0, and both syncs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request, sampled at frame boundaries |
| h_active | input | 12 | Horizontal active width |
| h_front | input | 12 | Horizontal front porch |
| h_sync | input | 12 | Hsync pulse width |
| h_back | input | 12 | Horizontal back porch |
| v_active | input | 12 | Vertical active lines |
| v_front | input | 12 | Vertical front porch |
| v_sync | input | 12 | Vsync pulse width in lines |
| v_back | input | 12 | Vertical back porch |
| hsync_low | input | 1 | Hsync active-low select |
| vsync_low | input | 1 | Vsync active-low select |
| link_kind | input | 2 | 0 generic, 1 serial panel, 2 packet link, 3 generic |
| wide_bus | input | 1 | Doubled bus width for the packet link |
| fetch_budget | input | 12 | Worst-case lines needed before active video |
| up_valid | input | 1 | Upstream pixel valid |
| up_pixel | input | 8 | Upstream pixel value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | 8 | Output pixel, fill or border colour |
| underrun | output | 1 | Active pixel with no upstream data |
| fetch_start | output | 1 | Early fetch pulse |
| vsync_irq | output | 1 | Frame start pulse |
| line_cnt | output | 14 | 1-based current line |
| frame_cnt | output | 16 | Reported frame number |
| timing_active | output | 1 | Engine running status |

## Verification
All outputs are decoded combinationally from the sweep registers. A pixel's results are therefore due in the first cycle after the clock edge that moves the sweep onto that pixel. The first pixel of a frame appears one edge after enable is sampled in ST_IDLE, or one edge after the previous frame's last pixel. A driver computes the expected outputs for every pixel of every frame from the field formulas and queues them in order. A monitor pops one entry a quarter period after each rising edge and compares every output. Shadow writes and the enable drop happen on falling edges in the middle of a frame, so each frame's effect lands on a known entry in the queue.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int FW = 12;        // width of one timing field
    localparam int TW = FW + 2;    // width of a per-axis total
    localparam int PW = 2 * TW;    // width of a frame pixel count

    typedef enum logic [1:0] {
        LK_GENERIC = 2'd0,
        LK_SERIAL  = 2'd1,
        LK_PACKET  = 2'd2,
        LK_SPARE   = 2'd3
    } link_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } run_state_e;

    typedef struct packed {
        logic [FW-1:0] act;
        logic [FW-1:0] fp;
        logic [FW-1:0] sw;
        logic [FW-1:0] bp;
    } axis_t;

    typedef struct packed {
        logic [FW-1:0] hact;
        logic [FW-1:0] hsw;
        logic [FW-1:0] hbp;
        logic [FW-1:0] vact;
        logic [FW-1:0] vfp;
        logic [FW-1:0] vsw;
        logic [FW-1:0] vbp;
        logic [TW-1:0] htot;
        logic [TW-1:0] vtot;
        logic          hs_low;
        logic          vs_low;
        logic          fetch_en;
        logic [PW-1:0] fetch_at;
    } active_cfg_t;

endpackage

// File: rtl/vtg_cfg_calc.sv
module vtg_cfg_calc
    import vtg_pkg::*;
(
    input  axis_t       h_in,
    input  axis_t       v_in,
    input  logic        hs_low_in,
    input  logic        vs_low_in,
    input  logic [1:0]  kind,
    input  logic        wide,
    input  logic [FW-1:0] budget,
    output active_cfg_t cfg
);

    logic          is_packet;
    logic          is_serial;
    logic [FW:0]   hbp_sum;
    logic [FW:0]   vbp_sum;
    axis_t         h_f;
    axis_t         v_f;
    logic [TW-1:0] ht;
    logic [TW-1:0] vt;
    logic [TW-1:0] sof;
    logic [TW-1:0] need;
    logic [TW-1:0] lines;

    always_comb begin
        is_packet = (kind == LK_PACKET);
        is_serial = (kind == LK_SERIAL);
        hbp_sum   = {1'b0, h_in.bp} + {1'b0, h_in.fp};
        vbp_sum   = {1'b0, v_in.bp} + {1'b0, v_in.fp};
        h_f       = h_in;
        v_f       = v_in;

        // packet link: front porch folds into back porch
        if (is_packet) begin
            h_f.fp = '0;
            h_f.bp = hbp_sum[FW-1:0];
            v_f.fp = '0;
            v_f.bp = vbp_sum[FW-1:0];
            if (wide) begin
                h_f.act = h_in.act >> 1;
                h_f.sw  = h_in.sw >> 1;
                h_f.bp  = hbp_sum[FW:1];
            end
        end

        ht = TW'(h_f.act) + TW'(h_f.fp) + TW'(h_f.sw) + TW'(h_f.bp);
        vt = TW'(v_f.act) + TW'(v_f.fp) + TW'(v_f.sw) + TW'(v_f.bp);

        // lines borrowed from the vertical front porch
        sof   = TW'(v_f.bp) + TW'(v_f.sw);
        need  = '0;
        lines = '0;
        if (sof < TW'(budget)) begin
            need  = TW'(budget) - sof;
            lines = (TW'(v_f.fp) < need) ? TW'(v_f.fp) : need;
        end

        cfg.hact     = h_f.act;
        cfg.hsw      = h_f.sw;
        cfg.hbp      = h_f.bp;
        cfg.vact     = v_f.act;
        cfg.vfp      = v_f.fp;
        cfg.vsw      = v_f.sw;
        cfg.vbp      = v_f.bp;
        cfg.htot     = ht;
        cfg.vtot     = vt;
        cfg.hs_low   = hs_low_in & ~is_serial;
        cfg.vs_low   = vs_low_in & ~is_serial;
        cfg.fetch_en = (lines != '0);
        cfg.fetch_at = PW'(vt - lines) * PW'(ht) + PW'(1);
    end

endmodule

// File: rtl/vtg_fsm.sv
module vtg_fsm
    import vtg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] htot,
    input  logic [TW-1:0] vtot,
    output run_state_e    state,
    output logic [TW-1:0] hpos,
    output logic [TW-1:0] vpos,
    output logic [PW-1:0] pcnt,
    output logic [CW-1:0] frames,
    output logic          load
);

    run_state_e nxt;
    logic       last_pix;
    logic       line_end;

    always_comb begin
        line_end = (hpos == htot - TW'(1));
        last_pix = line_end && (vpos == vtot - TW'(1));
        nxt      = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enable) begin
                    nxt  = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (last_pix) begin
                    if (enable) load = 1'b1;
                    else        nxt  = ST_IDLE;
                end else if (!enable) begin
                    nxt = ST_STOP;
                end
            end
            ST_STOP: begin
                if (last_pix) begin
                    if (enable) begin
                        nxt  = ST_RUN;
                        load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos   <= '0;
            vpos   <= '0;
            pcnt   <= PW'(1);
            frames <= '0;
        end else begin
            if (state == ST_IDLE || last_pix) begin
                hpos <= '0;
                vpos <= '0;
                pcnt <= PW'(1);
            end else begin
                pcnt <= pcnt + PW'(1);
                if (line_end) begin
                    hpos <= '0;
                    vpos <= vpos + TW'(1);
                end else begin
                    hpos <= hpos + TW'(1);
                end
            end
            if (state != ST_IDLE && last_pix) frames <= frames + CW'(1);
        end
    end

endmodule

// File: rtl/vtg_outgen.sv
module vtg_outgen
    import vtg_pkg::*;
#(
    parameter int             CW     = 16,
    parameter int             PIXW   = 8,
    parameter logic [PIXW-1:0] FILL   = '1,
    parameter logic [PIXW-1:0] BORDER = '0
) (
    input  run_state_e      state,
    input  logic [TW-1:0]   hpos,
    input  logic [TW-1:0]   vpos,
    input  logic [PW-1:0]   pcnt,
    input  logic [CW-1:0]   frames,
    input  logic [FW-1:0]   hact,
    input  logic [FW-1:0]   hsw,
    input  logic [FW-1:0]   hbp,
    input  logic [FW-1:0]   vact,
    input  logic [FW-1:0]   vfp,
    input  logic [FW-1:0]   vsw,
    input  logic [FW-1:0]   vbp,
    input  logic [TW-1:0]   vtot,
    input  logic            hs_low,
    input  logic            vs_low,
    input  logic            fetch_en,
    input  logic [PW-1:0]   fetch_at,
    input  logic            up_valid,
    input  logic [PIXW-1:0] up_pixel,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [PIXW-1:0] pix_out,
    output logic            underrun,
    output logic            fetch_start,
    output logic            vsync_irq,
    output logic [TW-1:0]   line_cnt,
    output logic [CW-1:0]   frame_cnt,
    output logic            timing_active
);

    logic          running;
    logic [TW-1:0] hstart;
    logic [TW-1:0] vstart;
    logic          de_h;
    logic          de_v;
    logic          in_win;

    always_comb begin
        running = (state != ST_IDLE);
        hstart  = TW'(hsw) + TW'(hbp);
        vstart  = TW'(vsw) + TW'(vbp);
        de_h    = (hpos >= hstart) && (hpos < hstart + TW'(hact));
        de_v    = (vpos >= vstart) && (vpos < vstart + TW'(vact));

        hsync   = (running && (hpos < TW'(hsw))) ^ hs_low;
        vsync   = (running && (vpos < TW'(vsw))) ^ vs_low;
        de      = running && de_h && de_v;

        underrun = de && !up_valid;
        if (!de)           pix_out = BORDER;
        else if (up_valid) pix_out = up_pixel;
        else               pix_out = FILL;

        line_cnt    = running ? (vpos + TW'(1)) : '0;
        in_win      = running && fetch_en &&
                      (line_cnt > vtot - TW'(vfp)) && (line_cnt <= vtot);
        frame_cnt   = frames + CW'(in_win);
        fetch_start = running && fetch_en && (pcnt == fetch_at);
        vsync_irq   = running && (hpos == '0) && (vpos == '0);
        timing_active = running;
    end

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
    import vtg_pkg::*;
#(
    parameter int              CW     = 16,
    parameter int              PIXW   = 8,
    parameter logic [PIXW-1:0] FILL   = 8'hFF,
    parameter logic [PIXW-1:0] BORDER = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [FW-1:0]   h_active,
    input  logic [FW-1:0]   h_front,
    input  logic [FW-1:0]   h_sync,
    input  logic [FW-1:0]   h_back,
    input  logic [FW-1:0]   v_active,
    input  logic [FW-1:0]   v_front,
    input  logic [FW-1:0]   v_sync,
    input  logic [FW-1:0]   v_back,
    input  logic            hsync_low,
    input  logic            vsync_low,
    input  logic [1:0]      link_kind,
    input  logic            wide_bus,
    input  logic [FW-1:0]   fetch_budget,
    input  logic            up_valid,
    input  logic [PIXW-1:0] up_pixel,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [PIXW-1:0] pix_out,
    output logic            underrun,
    output logic            fetch_start,
    output logic            vsync_irq,
    output logic [TW-1:0]   line_cnt,
    output logic [CW-1:0]   frame_cnt,
    output logic            timing_active
);

    axis_t         h_shadow;
    axis_t         v_shadow;
    active_cfg_t   cfg_next;
    active_cfg_t   cfg_act;
    run_state_e    state;
    logic [TW-1:0] hpos;
    logic [TW-1:0] vpos;
    logic [PW-1:0] pcnt;
    logic [CW-1:0] frames;
    logic          load;

    assign h_shadow = '{act: h_active, fp: h_front, sw: h_sync, bp: h_back};
    assign v_shadow = '{act: v_active, fp: v_front, sw: v_sync, bp: v_back};

    vtg_cfg_calc u_calc (
        .h_in      (h_shadow),
        .v_in      (v_shadow),
        .hs_low_in (hsync_low),
        .vs_low_in (vsync_low),
        .kind      (link_kind),
        .wide      (wide_bus),
        .budget    (fetch_budget),
        .cfg       (cfg_next)
    );

    // active timing set: copied from the shadow inputs only at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_act <= '0;
        else if (load) cfg_act <= cfg_next;
    end

    vtg_fsm #(.CW(CW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .htot   (cfg_act.htot),
        .vtot   (cfg_act.vtot),
        .state  (state),
        .hpos   (hpos),
        .vpos   (vpos),
        .pcnt   (pcnt),
        .frames (frames),
        .load   (load)
    );

    vtg_outgen #(
        .CW     (CW),
        .PIXW   (PIXW),
        .FILL   (FILL),
        .BORDER (BORDER)
    ) u_out (
        .state         (state),
        .hpos          (hpos),
        .vpos          (vpos),
        .pcnt          (pcnt),
        .frames        (frames),
        .hact          (cfg_act.hact),
        .hsw           (cfg_act.hsw),
        .hbp           (cfg_act.hbp),
        .vact          (cfg_act.vact),
        .vfp           (cfg_act.vfp),
        .vsw           (cfg_act.vsw),
        .vbp           (cfg_act.vbp),
        .vtot          (cfg_act.vtot),
        .hs_low        (cfg_act.hs_low),
        .vs_low        (cfg_act.vs_low),
        .fetch_en      (cfg_act.fetch_en),
        .fetch_at      (cfg_act.fetch_at),
        .up_valid      (up_valid),
        .up_pixel      (up_pixel),
        .hsync         (hsync),
        .vsync         (vsync),
        .de            (de),
        .pix_out       (pix_out),
        .underrun      (underrun),
        .fetch_start   (fetch_start),
        .vsync_irq     (vsync_irq),
        .line_cnt      (line_cnt),
        .frame_cnt     (frame_cnt),
        .timing_active (timing_active)
    );

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
#(
    parameter int              PIXW = 8,
    parameter logic [PIXW-1:0] FILL = 8'hFF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            timing_active,
    input logic            de,
    input logic            fetch_start,
    input logic            vsync_irq,
    input logic            underrun,
    input logic [PIXW-1:0] pix_out,
    input logic [TW-1:0]   line_cnt
);

    // R8: an underrun pixel carries the fill colour
    a_r8_fill_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (de && pix_out == FILL));

    // R10: the engine only stops after a cycle with enable low
    a_r10_stop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timing_active) |-> !$past(enable));

    // R12: an idle engine is quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_active |-> (!de && !fetch_start && !vsync_irq && !underrun));

    // R9: frame-start pulse sits on the first line
    a_r9_irq_first_line: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_irq |-> (line_cnt == TW'(1)));

    // R6: the early fetch point lies outside the active window
    a_r6_fetch_outside_de: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> !de);

endmodule

bind frame_timing_gen vtg_checker #(.PIXW(PIXW), .FILL(FILL)) u_vtg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .timing_active (timing_active),
    .de            (de),
    .fetch_start   (fetch_start),
    .vsync_irq     (vsync_irq),
    .underrun      (underrun),
    .pix_out       (pix_out),
    .line_cnt      (line_cnt)
);

// File: tb/test_frame_timing_gen.sv
module test_frame_timing_gen;
    import vtg_pkg::*;

    localparam int CLK_P = 10;
    localparam int PIX_OK = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [FW-1:0] h_active = '0, h_front = '0, h_sync = '0, h_back = '0;
    logic [FW-1:0] v_active = '0, v_front = '0, v_sync = '0, v_back = '0;
    logic hsync_low = 1'b0, vsync_low = 1'b0, wide_bus = 1'b0, up_valid = 1'b1;
    logic [1:0] link_kind = 2'd0;
    logic [FW-1:0] fetch_budget = '0;
    logic [7:0] up_pixel = 8'(PIX_OK);
    logic hsync, vsync, de, underrun, fetch_start, vsync_irq, timing_active;
    logic [7:0] pix_out;
    logic [TW-1:0] line_cnt;
    logic [15:0] frame_cnt;

    frame_timing_gen i_frame_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .h_active(h_active), .h_front(h_front), .h_sync(h_sync), .h_back(h_back),
        .v_active(v_active), .v_front(v_front), .v_sync(v_sync), .v_back(v_back),
        .hsync_low(hsync_low), .vsync_low(vsync_low), .link_kind(link_kind),
        .wide_bus(wide_bus), .fetch_budget(fetch_budget),
        .up_valid(up_valid), .up_pixel(up_pixel),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
        .underrun(underrun), .fetch_start(fetch_start), .vsync_irq(vsync_irq),
        .line_cnt(line_cnt), .frame_cnt(frame_cnt), .timing_active(timing_active)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int ha, hf, hs, hb, va, vf, vs, vb;
        bit hl, vl;
        int kind;
        bit wide;
        int budget;
    } raw_t;

    typedef struct {
        int ha, hs, hb, va, vf, vs, vb, ht, vt, lines, fat;
        bit hl, vl, fen;
    } eff_t;

    typedef struct {
        int hs, vs, de, fs, irq, und, act, line, frame, pix;
        string tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    int exp_frames = 0;
    bit last_hl = 1'b0;
    bit last_vl = 1'b0;

    task automatic chk(string what, string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // effective timing from the field rules (R2, R3, R4, R6)
    function automatic eff_t calc(raw_t r);
        eff_t e;
        int hf, vf, sof, need;
        e.ha = r.ha; e.hs = r.hs; e.hb = r.hb; hf = r.hf;
        e.va = r.va; e.vs = r.vs; e.vb = r.vb; vf = r.vf;
        if (r.kind == 2) begin
            e.hb = r.hb + r.hf; hf = 0;
            e.vb = r.vb + r.vf; vf = 0;
            if (r.wide) begin
                e.ha = r.ha / 2; e.hs = r.hs / 2; e.hb = e.hb / 2;
            end
        end
        e.vf = vf;
        e.ht = e.ha + hf + e.hs + e.hb;
        e.vt = e.va + vf + e.vs + e.vb;
        e.hl = (r.kind == 1) ? 1'b0 : r.hl;
        e.vl = (r.kind == 1) ? 1'b0 : r.vl;
        sof = e.vb + e.vs;
        e.lines = 0;
        if (sof < r.budget) begin
            need = r.budget - sof;
            e.lines = (vf < need) ? vf : need;
        end
        e.fen = (e.lines != 0);
        e.fat = (e.vt - e.lines) * e.ht + 1;
        return e;
    endfunction

    task automatic apply(raw_t r);
        h_active = FW'(r.ha); h_front = FW'(r.hf); h_sync = FW'(r.hs); h_back = FW'(r.hb);
        v_active = FW'(r.va); v_front = FW'(r.vf); v_sync = FW'(r.vs); v_back = FW'(r.vb);
        hsync_low = r.hl; vsync_low = r.vl; link_kind = 2'(r.kind);
        wide_bus = r.wide; fetch_budget = FW'(r.budget);
    endtask

    // driver: queue every pixel of nfr frames, then let them play out
    task automatic play(raw_t r, int nfr, bit valid, string tag,
                        bit drop, bit mid, raw_t r2);
        eff_t e;
        int tot;
        e = calc(r);
        apply(r);
        enable = 1'b1;
        up_valid = valid;
        tot = e.ht * e.vt;
        for (int f = 0; f < nfr; f++) begin
            for (int p = 0; p < tot; p++) begin
                item_t it;
                int x, y, ln;
                bit dh, dv, win;
                x = p % e.ht; y = p / e.ht; ln = y + 1;
                dh = (x >= e.hs + e.hb) && (x < e.hs + e.hb + e.ha);
                dv = (y >= e.vs + e.vb) && (y < e.vs + e.vb + e.va);
                win = e.fen && (ln > e.vt - e.vf) && (ln <= e.vt);
                it.hs = int'((x < e.hs) ^ e.hl);
                it.vs = int'((y < e.vs) ^ e.vl);
                it.de = int'(dh && dv);
                it.fs = int'(e.fen && (p + 1 == e.fat));
                it.irq = int'(p == 0);
                it.und = int'(dh && dv && !valid);
                it.act = 1;
                it.line = ln;
                it.frame = exp_frames + f + int'(win);
                it.pix = (dh && dv) ? (valid ? PIX_OK : 255) : 0;
                it.tag = tag;
                q.push_back(it);
            end
        end
        last_hl = e.hl;
        last_vl = e.vl;
        for (int i = 1; i <= nfr * tot; i++) begin
            @(negedge clk);
            if (i == (nfr * tot) / 2) begin
                if (drop) enable = 1'b0;
                if (mid) apply(r2);
            end
        end
        exp_frames += nfr;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.hs = int'(last_hl); it.vs = int'(last_vl);
            it.de = 0; it.fs = 0; it.irq = 0; it.und = 0; it.act = 0;
            it.line = 0; it.frame = exp_frames; it.pix = 0; it.tag = tag;
            q.push_back(it);
        end
        repeat (n) @(negedge clk);
    endtask

    // monitor: one expected entry per pixel clock
    initial begin
        forever begin
            item_t it;
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                it = q.pop_front();
                chk("hsync R1", it.tag, int'(hsync), it.hs);
                chk("vsync R1", it.tag, int'(vsync), it.vs);
                chk("de R5", it.tag, int'(de), it.de);
                chk("fetch_start R6", it.tag, int'(fetch_start), it.fs);
                chk("vsync_irq R9", it.tag, int'(vsync_irq), it.irq);
                chk("underrun R8", it.tag, int'(underrun), it.und);
                chk("pix_out R8", it.tag, int'(pix_out), it.pix);
                chk("line_cnt R7", it.tag, int'(line_cnt), it.line);
                chk("frame_cnt R7", it.tag, int'(frame_cnt), it.frame);
                chk("timing_active R10", it.tag, int'(timing_active), it.act);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        raw_t base, lowp, serial, pkt, pktw, bigb, nof, midc;
        base = '{ha:8, hf:2, hs:1, hb:3, va:4, vf:3, vs:1, vb:1,
                 hl:1'b0, vl:1'b0, kind:0, wide:1'b0, budget:4};
        lowp = base;   lowp.hl = 1'b1; lowp.vl = 1'b1;
        serial = lowp; serial.kind = 1;
        pkt = base;    pkt.kind = 2;
        pktw = base;   pktw.kind = 2; pktw.wide = 1'b1; pktw.hs = 2;
        bigb = base;   bigb.budget = 10;
        nof = base;    nof.budget = 1;
        midc = base;   midc.ha = 6; midc.vs = 2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4, "R12");                              // R12 reset state
        play(base, 2, 1'b1, "R1", 1'b0, 1'b0, base); // R1 R5 R6 R7 R9
        play(lowp, 1, 1'b1, "R2", 1'b0, 1'b0, base); // R2 inverted syncs
        play(serial, 1, 1'b1, "R2", 1'b0, 1'b0, base); // R2 serial forces high
        play(pkt, 1, 1'b1, "R3", 1'b0, 1'b0, base);  // R3 folded porches
        play(pktw, 1, 1'b1, "R4", 1'b0, 1'b0, base); // R4 halved horizontal
        play(bigb, 1, 1'b1, "R6", 1'b0, 1'b0, base); // R6 capped by front porch
        play(nof, 1, 1'b1, "R6", 1'b0, 1'b0, base);  // R6 no early fetch
        play(base, 1, 1'b0, "R8", 1'b0, 1'b0, base); // R8 underflow fill
        play(base, 1, 1'b1, "R11", 1'b0, 1'b1, midc); // R11 mid-frame write
        play(midc, 1, 1'b1, "R11", 1'b0, 1'b0, base);
        play(base, 1, 1'b1, "R10", 1'b1, 1'b0, base); // R10 drop mid-frame
        idle(6, "R10");
        play(base, 1, 1'b1, "R10", 1'b0, 1'b0, base);
        wait (q.size() == 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule